// File: doc/BRIEF.md
# Dual-Mode Framed Serial Sample Port

This block carries 16-bit samples between a converter-side parallel interface and a host serial port. One serial line goes out and one comes in. Each direction has its own active-low frame strobe and its own active-low end-of-data strobe. Everything runs on a single shift clock. A transmit bit is launched on the rising edge. A receive bit is captured on the falling edge. Bits travel most significant first.

Two inputs set the framing. The width input chooses between two shapes. In word framing the sample moves as one 16-bit burst. In byte framing it moves as two 8-bit halves, with a frame-strobe pulse between them. The lock input chooses how the two directions relate. With lock off, each direction is started by its own strobe. With lock on, the receive frame follows the transmit frame. A transmit request marked secondary then produces no receive frame at all, because it carries control traffic and no new converter result exists.

Top module: `sp_port`

## Requirements
- R1: `word_mode_i`=1 selects word framing and 0 selects byte framing. `sync_ctrl_i`=1 locks receive framing to transmit framing and 0 keeps the directions independent. A start accepted on clock edge k makes the cycle after edge k the first cycle of the frame.
- R2: Byte framing, first half: the frame strobe is low for 8 cycles and the end-of-data strobe is high. Sample bits 15 down to 8 appear, one per cycle, MSB first.
- R3: Byte framing, middle: after the first half, the end-of-data strobe goes low and the frame strobe is high for exactly 4 cycles.
- R4: Byte framing, second half: the frame strobe is low for 8 cycles with the end-of-data strobe still low, carrying bits 7 down to 0. Then one cycle follows with the end-of-data strobe high and the frame strobe still low. Then both strobes are idle high.
- R5: Word framing: the frame strobe is low for 16 cycles carrying bits 15 down to 0. The next cycle has the frame strobe high and the end-of-data strobe low for exactly one cycle. Then the port is idle.
- R6: Each receive bit is taken from `rx_sd_i` on the falling clock edge of its bit cycle. `rx_valid_o` is high for exactly one cycle, the cycle after the last bit cycle. In that cycle `rx_data_o` holds the assembled sample, first received bit in bit 15.
- R7: With the lock off, the receive frame is started only by `rx_start_i` and may be offset from the transmit frame or absent. The transmit frame is started only by `tx_start_i`.
- R8: With the lock on, a transmit start with `tx_primary_i`=1 starts a receive frame whose strobes match the transmit strobes cycle for cycle. `rx_start_i` is ignored.
- R9: With the lock on, a transmit start with `tx_primary_i`=0 leaves the receive strobes high, produces no `rx_valid_o`, and leaves the transmit frame unchanged.
- R10: The framing width is sampled only when a start is accepted in idle. A start or a width change during a frame has no effect on that frame.
- R11: During reset, all four strobes are high, `tx_sd_o` is 0 and `rx_valid_o` is 0.
- R12: `tx_sd_o` is 0 in every cycle in which the transmit frame strobe is high and in the closing cycle of byte framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode_i | input | 1 | 1: word framing, 0: byte framing |
| sync_ctrl_i | input | 1 | 1: receive framing locked to transmit |
| tx_start_i | input | 1 | One-cycle transmit start strobe |
| tx_primary_i | input | 1 | Qualifies the transmit start as primary (1) or secondary (0) |
| tx_data_i | input | 16 | Sample to transmit, loaded at start |
| rx_start_i | input | 1 | One-cycle receive start strobe, used with the lock off |
| rx_sd_i | input | 1 | Serial receive data |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_frame_n_o | output | 1 | Transmit frame strobe, active low |
| tx_eod_n_o | output | 1 | Transmit end-of-data strobe, active low |
| rx_frame_n_o | output | 1 | Receive frame strobe, active low |
| rx_eod_n_o | output | 1 | Receive end-of-data strobe, active low |
| rx_data_o | output | 16 | Received sample |
| rx_valid_o | output | 1 | One-cycle flag that `rx_data_o` is complete |

## Verification
Frames are run in both widths with alternating, walking and one-hot-edge samples, so that a reversed bit order or a swapped half shows up as a wrong bit in a known cycle. Unlocked runs start the receive frame at the same time as transmit, later than transmit, or not at all. These tell real independence apart from a shared sequencer. Locked runs use both primary and secondary requests, with a stray receive start present. They show whether receive follows transmit and whether it is correctly suppressed. Directed runs flip the width and repeat the start in the middle of a frame, which shows that the width is held per frame.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HEAD,    // first half bits, frame low
      ST_GAP,     // frame high pulse, eod low
      ST_BODY,    // second half bits, eod low
      ST_CLOSE,   // eod released, frame still low
      ST_WORD,    // full sample bits
      ST_MARK     // eod low pulse after word
   } sp_state_e;
endpackage

// File: rtl/sp_framer.sv
module sp_framer
   import sp_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int GAP_CYC  = 4,
   parameter bit CAPTURE  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                word_mode_i,
   input  logic [SAMPLE_W-1:0] load_i,
   input  logic                ser_i,
   output logic                ser_o,
   output logic                frame_n_o,
   output logic                eod_n_o,
   output logic [SAMPLE_W-1:0] data_o,
   output logic                valid_o
);
   localparam int HALF = SAMPLE_W / 2;
   localparam int CW   = $clog2(SAMPLE_W + GAP_CYC + 1);

   sp_state_e           state_q;
   logic [CW-1:0]       cnt_q;
   logic [SAMPLE_W-1:0] shreg_q;
   logic [SAMPLE_W-1:0] load_val;
   logic                valid_q;
   logic                bit_in;
   logic                shifting;

   assign shifting = (state_q == ST_HEAD) || (state_q == ST_BODY) ||
                     (state_q == ST_WORD);

   generate
      if (CAPTURE) begin : g_rx
         logic samp_q;
         logic load_unused;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) samp_q <= 1'b0;
            else        samp_q <= ser_i;
         end
         assign bit_in      = samp_q;
         assign load_val    = '0;
         assign ser_o       = 1'b0;
         assign load_unused = ^load_i;
      end else begin : g_tx
         logic ser_unused;
         assign bit_in     = 1'b0;
         assign load_val   = load_i;
         assign ser_o      = shifting & shreg_q[SAMPLE_W-1];
         assign ser_unused = ser_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         shreg_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (shifting) shreg_q <= {shreg_q[SAMPLE_W-2:0], bit_in};
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= word_mode_i ? ST_WORD : ST_HEAD;
                  cnt_q   <= '0;
                  shreg_q <= load_val;
               end
            end
            ST_HEAD: begin
               if (cnt_q == CW'(HALF - 1)) begin
                  state_q <= ST_GAP;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_GAP: begin
               if (cnt_q == CW'(GAP_CYC - 1)) begin
                  state_q <= ST_BODY;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_BODY: begin
               if (cnt_q == CW'(HALF - 1)) begin
                  state_q <= ST_CLOSE;
                  cnt_q   <= '0;
                  valid_q <= 1'b1;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_WORD: begin
               if (cnt_q == CW'(SAMPLE_W - 1)) begin
                  state_q <= ST_MARK;
                  cnt_q   <= '0;
                  valid_q <= 1'b1;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_CLOSE: state_q <= ST_IDLE;
            ST_MARK:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign frame_n_o = !((state_q == ST_HEAD) || (state_q == ST_BODY) ||
                        (state_q == ST_CLOSE) || (state_q == ST_WORD));
   assign eod_n_o   = !((state_q == ST_GAP) || (state_q == ST_BODY) ||
                        (state_q == ST_MARK));
   assign data_o    = shreg_q;
   assign valid_o   = valid_q;
endmodule

// File: rtl/sp_port.sv
module sp_port #(
   parameter int SAMPLE_W = 16,
   parameter int GAP_CYC  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word_mode_i,
   input  logic                sync_ctrl_i,
   input  logic                tx_start_i,
   input  logic                tx_primary_i,
   input  logic [SAMPLE_W-1:0] tx_data_i,
   input  logic                rx_start_i,
   input  logic                rx_sd_i,
   output logic                tx_sd_o,
   output logic                tx_frame_n_o,
   output logic                tx_eod_n_o,
   output logic                rx_frame_n_o,
   output logic                rx_eod_n_o,
   output logic [SAMPLE_W-1:0] rx_data_o,
   output logic                rx_valid_o
);
   generate
      if ((SAMPLE_W % 2) != 0 || SAMPLE_W < 4) begin : g_bad_width
         $error("sp_port: SAMPLE_W must be even and at least 4");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("sp_port: GAP_CYC must be at least 1");
      end
   endgenerate

   logic                rx_go;
   logic                rx_ser_unused;
   logic                tx_valid_unused;
   logic [SAMPLE_W-1:0] tx_data_unused;

   // locked: receive follows primary transmit requests only
   assign rx_go = sync_ctrl_i ? (tx_start_i & tx_primary_i) : rx_start_i;

   sp_framer #(.SAMPLE_W(SAMPLE_W), .GAP_CYC(GAP_CYC), .CAPTURE(1'b0)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (tx_start_i),
      .word_mode_i (word_mode_i),
      .load_i      (tx_data_i),
      .ser_i       (1'b0),
      .ser_o       (tx_sd_o),
      .frame_n_o   (tx_frame_n_o),
      .eod_n_o     (tx_eod_n_o),
      .data_o      (tx_data_unused),
      .valid_o     (tx_valid_unused)
   );

   sp_framer #(.SAMPLE_W(SAMPLE_W), .GAP_CYC(GAP_CYC), .CAPTURE(1'b1)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (rx_go),
      .word_mode_i (word_mode_i),
      .load_i      ({SAMPLE_W{1'b0}}),
      .ser_i       (rx_sd_i),
      .ser_o       (rx_ser_unused),
      .frame_n_o   (rx_frame_n_o),
      .eod_n_o     (rx_eod_n_o),
      .data_o      (rx_data_o),
      .valid_o     (rx_valid_o)
   );
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk #(
   parameter int GAP_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic sync_ctrl_i,
   input logic tx_sd_o,
   input logic tx_frame_n_o,
   input logic tx_eod_n_o,
   input logic rx_frame_n_o,
   input logic rx_valid_o
);
   localparam int RW = $clog2(GAP_CYC + 2);

   logic          in_run;
   logic [RW-1:0] run_q;

   assign in_run = tx_frame_n_o & !tx_eod_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= '0;
      else if (!in_run)                run_q <= '0;
      else if (run_q != RW'(GAP_CYC + 1)) run_q <= run_q + 1'b1;
   end

   // byte gap: frame-high/eod-low run that ends with frame low is GAP_CYC long
   assert_gap_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != '0 && !in_run && !tx_frame_n_o) |-> run_q == RW'(GAP_CYC));

   // word marker: run that ends with eod released is one cycle long
   assert_eod_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != '0 && !in_run && tx_eod_n_o) |-> run_q == RW'(1));

   assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   assert_rx_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rx_frame_n_o) && $past(sync_ctrl_i) && sync_ctrl_i) |-> $fell(tx_frame_n_o));

   assert_quiet_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_n_o |-> !tx_sd_o);
endmodule

bind sp_port sp_port_chk #(.GAP_CYC(GAP_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sync_ctrl_i  (sync_ctrl_i),
   .tx_sd_o      (tx_sd_o),
   .tx_frame_n_o (tx_frame_n_o),
   .tx_eod_n_o   (tx_eod_n_o),
   .rx_frame_n_o (rx_frame_n_o),
   .rx_valid_o   (rx_valid_o)
);

// File: tb/tb_sp_port.sv
module tb_sp_port;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        word_mode_i, sync_ctrl_i, tx_start_i, tx_primary_i, rx_start_i, rx_sd_i;
   logic [15:0] tx_data_i;
   logic        tx_sd_o, tx_frame_n_o, tx_eod_n_o, rx_frame_n_o, rx_eod_n_o, rx_valid_o;
   logic [15:0] rx_data_o;
   int          n_run = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   sp_port dut (
      .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode_i), .sync_ctrl_i(sync_ctrl_i),
      .tx_start_i(tx_start_i), .tx_primary_i(tx_primary_i), .tx_data_i(tx_data_i),
      .rx_start_i(rx_start_i), .rx_sd_i(rx_sd_i), .tx_sd_o(tx_sd_o),
      .tx_frame_n_o(tx_frame_n_o), .tx_eod_n_o(tx_eod_n_o), .rx_frame_n_o(rx_frame_n_o),
      .rx_eod_n_o(rx_eod_n_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
   );

   typedef struct packed {
      logic        word;
      logic        sync;
      logic        prim;
      logic        rxen;
      logic [3:0]  ofs;
      logic [15:0] txd;
      logic [15:0] rxd;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 16'hA5C3, 16'h3C96},
      '{1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 16'h8001, 16'h7FFE},
      '{1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 16'h1234, 16'hABCD},
      '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 16'hF00F, 16'h0FF0},
      '{1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 16'h5A5A, 16'hFFFF},
      '{1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0100, 16'h0000}
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R2/R3/R4/R6 byte both";
         1: return "R5/R6 word both";
         2: return "R7 rx offset";
         3: return "R8 locked primary";
         4: return "R9 locked secondary";
         default: return "R7 tx only";
      endcase
   endfunction

   // {valid, frame_n, eod_n, hasbit, idx[3:0]} for frame cycle k
   function automatic logic [7:0] exp_at(logic word, int k);
      if (k < 0) return 8'b0110_0000;
      if (word) begin
         if (k < 16)  return {1'b0, 1'b0, 1'b1, 1'b1, 4'(15 - k)};
         if (k == 16) return 8'b1100_0000;
      end else begin
         if (k < 8)   return {1'b0, 1'b0, 1'b1, 1'b1, 4'(15 - k)};
         if (k < 12)  return 8'b0100_0000;
         if (k < 20)  return {1'b0, 1'b0, 1'b0, 1'b1, 4'(19 - k)};
         if (k == 20) return 8'b1010_0000;
      end
      return 8'b0110_0000;
   endfunction

   task automatic xfer(input vec_t v, input bit poke, input string tag);
      logic rx_act;
      int   roff;
      int   len;
      rx_act = v.sync ? v.prim : v.rxen;
      roff   = v.sync ? 0 : int'(v.ofs);
      len    = v.word ? 17 : 21;
      word_mode_i  = v.word;
      sync_ctrl_i  = v.sync;
      tx_primary_i = v.prim;
      tx_data_i    = v.txd;
      tx_start_i   = 1'b1;
      rx_start_i   = v.rxen && (v.ofs == 0);
      for (int c = 0; c < len + roff + 2; c++) begin
         logic [7:0] et, er;
         logic       e_sd, e_rv, ok;
         @(posedge clk); #5;
         tx_start_i = 1'b0;
         rx_start_i = v.rxen && (c == int'(v.ofs) - 1);
         if (poke && c == 5) begin
            word_mode_i = ~v.word;
            tx_start_i  = 1'b1;
            rx_start_i  = 1'b1;
         end
         et = exp_at(v.word, c);
         er = rx_act ? exp_at(v.word, c - roff) : 8'b0110_0000;
         rx_sd_i = er[4] ? v.rxd[er[3:0]] : 1'b0;
         e_sd = et[4] ? v.txd[et[3:0]] : 1'b0;
         e_rv = er[7];
         ok = (tx_frame_n_o == et[6]) && (tx_eod_n_o == et[5]) && (tx_sd_o == e_sd) &&
              (rx_frame_n_o == er[6]) && (rx_eod_n_o == er[5]) && (rx_valid_o == e_rv) &&
              (!e_rv || rx_data_o == v.rxd);
         n_run++;
         if (!ok) begin
            n_fail++;
            $display("FAIL %s cyc %0d: got tx f/e/d=%b%b%b rx f/e/v=%b%b%b data=%h, exp tx %b%b%b rx %b%b%b data=%h",
                     tag, c, tx_frame_n_o, tx_eod_n_o, tx_sd_o, rx_frame_n_o, rx_eod_n_o,
                     rx_valid_o, rx_data_o, et[6], et[5], e_sd, er[6], er[5], e_rv, v.rxd);
         end
      end
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; word_mode_i = 1'b0; sync_ctrl_i = 1'b0; tx_start_i = 1'b0;
      tx_primary_i = 1'b0; rx_start_i = 1'b0; rx_sd_i = 1'b0; tx_data_i = '0;
      repeat (3) @(posedge clk);
      #5;
      // R11: reset state
      n_run++;
      if (!(tx_frame_n_o && tx_eod_n_o && rx_frame_n_o && rx_eod_n_o && !tx_sd_o && !rx_valid_o)) begin
         n_fail++;
         $display("FAIL R11 reset: got %b%b%b%b sd=%b v=%b, exp 1111 sd=0 v=0",
                  tx_frame_n_o, tx_eod_n_o, rx_frame_n_o, rx_eod_n_o, tx_sd_o, rx_valid_o);
      end
      rst_n = 1'b1;
      @(posedge clk); #5;

      for (int i = 0; i < NV; i++) xfer(VECS[i], 1'b0, tag_of(i));

      // R10: width flip and repeated start mid-frame are ignored
      xfer('{1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 16'hC001, 16'h8421}, 1'b1, "R10 byte poke");
      xfer('{1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 16'h6DB6, 16'h1111}, 1'b1, "R10 word poke");
      // R1: locked byte framing with matching strobes
      xfer('{1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 16'hFFFF, 16'h0001}, 1'b0, "R1 locked byte");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule